// File: doc/BRIEF.md
# PS/2 Keyboard Key-Event Receiver

This block listens to a keyboard on the two-wire PS/2 bus and reports whole key events. Both bus lines come in as plain inputs. The open-collector pull-ups sit outside the block, and the host never drives the bus. Each line passes through a two-flop synchroniser and then a stability filter. The receiver then looks for falling edges on the conditioned clock and reads one 11-bit frame at a time. It checks the start, parity and stop bits of each frame.

The key-up prefix (0xF0) and the extended-key prefix (0xE0) are not reported on their own. Each one is stored as a pending flag and attached to the next real scan code. A finished key then appears as one event: a one-cycle `evt_valid` strobe, with the code and two flags held on the outputs until the next event. A frame that fails its checks raises a one-cycle `frame_err` pulse and clears any pending prefixes. If the clock stops in the middle of a frame, the partial frame is dropped after a programmable silence.

Top module: `kbd_event_rx`

## Requirements
- R1: After synchronous reset, `evt_valid`, `frame_err`, `evt_code`, `evt_break` and `evt_ext` are all 0.
- R2: A frame is sampled on falling edges of the conditioned PS/2 clock. It holds a 0 start bit, eight data bits with the least significant bit first, an odd parity bit (the nine bits carry an odd number of ones), and a 1 stop bit. A valid non-prefix byte with no pending prefix gives one event with `evt_code` = byte, `evt_break` = 0 and `evt_ext` = 0.
- R3: A valid byte 0xF0 gives no event. The next scan code is reported with `evt_break` = 1.
- R4: A valid byte 0xE0 gives no event. The next scan code is reported with `evt_ext` = 1. The sequence E0, F0, code gives one event with both flags set.
- R5: The same make code received several times in a row gives one event per frame, each with `evt_break` = 0.
- R6: A frame with wrong parity gives no event, a `frame_err` pulse, and clears pending prefix flags.
- R7: A frame whose stop bit is 0 gives no event, a `frame_err` pulse, and clears pending prefix flags.
- R8: If no conditioned clock falling edge arrives for `IDLE_LIMIT` cycles during a frame, the partial frame is discarded without an error. The next frame is then decoded normally.
- R9: A pulse on a PS/2 line shorter than `FILTER_LEN` system cycles has no effect on decoding.
- R10: `evt_valid` and `frame_err` are never high for two cycles in a row. `evt_code` and the flags keep their values between events.
- R11: A falling clock edge while idle with the data line high is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_in | input | 1 | PS/2 clock line as seen at the pin (idle high) |
| ps2_data_in | input | 1 | PS/2 data line as seen at the pin (idle high) |
| evt_valid | output | 1 | One-cycle strobe: a key event is on the outputs |
| evt_code | output | 8 | Scan code of the last event |
| evt_break | output | 1 | Last event was a key release |
| evt_ext | output | 1 | Last event was an extended key |
| frame_err | output | 1 | One-cycle pulse: a frame failed its parity or stop check |

## Verification
The assertions assume that the conditioned clock line changes far less often than the system clock. They also assume that two complete frames are many cycles apart, so a byte strobe is never followed by another within one cycle. The stimulus keeps to this: every half-period of the PS/2 clock lasts tens of system cycles, and data changes only at the start of a clock-high phase. Two stimuli fall outside the normal protocol on purpose: a glitch shorter than the filter window, and a deliberately abandoned frame. Both are bounded so that only the filter and the silence timeout are exercised.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam logic [7:0] PFX_RELEASE  = 8'hF0;
  localparam logic [7:0] PFX_EXTENDED = 8'hE0;
  localparam int         FRAME_BITS   = 11;
  localparam logic [3:0] LAST_BIT     = 4'(FRAME_BITS - 1);

  typedef struct packed {
    logic       brk;
    logic       ext;
    logic [7:0] code;
  } key_evt_t;
endpackage

// File: rtl/kbd_line_filter.sv
module kbd_line_filter #(
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      clean   <= 1'b1;
      run_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] != clean) begin
        if (run_cnt == CW'(STABLE_CYC - 1)) begin
          clean   <= sync_q[1];
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end

  // R9: the clean line only moves to a value the synchroniser has presented
  a_r9_follows_sync: assert property (@(posedge clk) disable iff (rst)
    !$stable(clean) |-> clean == $past(sync_q[1]));
  // R9: the run counter never passes the filter window
  a_r9_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run_cnt < CW'(STABLE_CYC));
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_pkg::*;
#(
  parameter int IDLE_LIMIT = 250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_clk,
  input  logic       line_dat,
  output logic       byte_ok,
  output logic       byte_bad,
  output logic [7:0] byte_data
);
  localparam int TW = $clog2(IDLE_LIMIT + 1);

  logic          clk_q;
  logic          fall;
  logic [3:0]    bit_idx;
  logic [7:0]    shreg;
  logic          par_bit;
  logic [TW-1:0] quiet_cnt;

  assign fall = clk_q & ~line_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q     <= 1'b1;
      bit_idx   <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      quiet_cnt <= '0;
      byte_ok   <= 1'b0;
      byte_bad  <= 1'b0;
      byte_data <= '0;
    end else begin
      clk_q    <= line_clk;
      byte_ok  <= 1'b0;
      byte_bad <= 1'b0;
      if (fall) begin
        quiet_cnt <= '0;
        if (bit_idx == 4'd0) begin
          if (!line_dat) bit_idx <= 4'd1;
        end else if (bit_idx <= 4'd8) begin
          shreg   <= {line_dat, shreg[7:1]};
          bit_idx <= bit_idx + 4'd1;
        end else if (bit_idx == 4'd9) begin
          par_bit <= line_dat;
          bit_idx <= LAST_BIT;
        end else begin
          bit_idx   <= '0;
          byte_data <= shreg;
          if (line_dat && (^{shreg, par_bit})) byte_ok  <= 1'b1;
          else                                 byte_bad <= 1'b1;
        end
      end else if (bit_idx != 4'd0) begin
        if (quiet_cnt == TW'(IDLE_LIMIT - 1)) begin
          bit_idx   <= '0;
          quiet_cnt <= '0;
        end else begin
          quiet_cnt <= quiet_cnt + 1'b1;
        end
      end
    end
  end

  a_r2_index_range: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= LAST_BIT);
  a_r6_ok_bad_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(byte_ok && byte_bad));
  a_r2_result_on_stop_edge: assert property (@(posedge clk) disable iff (rst)
    (byte_ok || byte_bad) |-> ($past(fall) && $past(bit_idx) == LAST_BIT));
  a_r8_quiet_bounded: assert property (@(posedge clk) disable iff (rst)
    quiet_cnt < TW'(IDLE_LIMIT));
endmodule

// File: rtl/kbd_event_fsm.sv
module kbd_event_fsm
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_ok,
  input  logic       byte_bad,
  input  logic [7:0] byte_data,
  output logic       evt_valid,
  output key_evt_t   evt,
  output logic       frame_err
);
  logic pend_brk;
  logic pend_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_brk  <= 1'b0;
      pend_ext  <= 1'b0;
      evt_valid <= 1'b0;
      evt       <= '0;
      frame_err <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      frame_err <= 1'b0;
      if (byte_bad) begin
        pend_brk  <= 1'b0;
        pend_ext  <= 1'b0;
        frame_err <= 1'b1;
      end else if (byte_ok) begin
        if (byte_data == PFX_EXTENDED) begin
          pend_ext <= 1'b1;
        end else if (byte_data == PFX_RELEASE) begin
          pend_brk <= 1'b1;
        end else begin
          evt_valid <= 1'b1;
          evt       <= '{brk: pend_brk, ext: pend_ext, code: byte_data};
          pend_brk  <= 1'b0;
          pend_ext  <= 1'b0;
        end
      end
    end
  end

  // R3, R4: prefixes are folded into flags, never reported as codes
  a_r3_no_prefix_event: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt.code != PFX_RELEASE && evt.code != PFX_EXTENDED));
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> !evt_valid);
  a_r10_single_err: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);
  a_r6_err_clears_prefix: assert property (@(posedge clk) disable iff (rst)
    $past(byte_bad) |-> (!pend_brk && !pend_ext));
  a_r6_err_no_event: assert property (@(posedge clk) disable iff (rst)
    !(evt_valid && frame_err));
  a_r10_code_held: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |-> $stable(evt));
endmodule

// File: rtl/kbd_event_rx.sv
module kbd_event_rx
  import kbd_pkg::*;
#(
  parameter int FILTER_LEN = 4,
  parameter int IDLE_LIMIT = 250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_in,
  input  logic       ps2_data_in,
  output logic       evt_valid,
  output logic [7:0] evt_code,
  output logic       evt_break,
  output logic       evt_ext,
  output logic       frame_err
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] clean_lines;
  logic              byte_ok;
  logic              byte_bad;
  logic [7:0]        byte_data;
  key_evt_t          evt;

  assign raw_lines = {ps2_data_in, ps2_clk_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    kbd_line_filter #(.STABLE_CYC(FILTER_LEN)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .raw   (raw_lines[g]),
      .clean (clean_lines[g])
    );
  end

  kbd_frame_rx #(.IDLE_LIMIT(IDLE_LIMIT)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .line_clk  (clean_lines[0]),
    .line_dat  (clean_lines[1]),
    .byte_ok   (byte_ok),
    .byte_bad  (byte_bad),
    .byte_data (byte_data)
  );

  kbd_event_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .byte_ok   (byte_ok),
    .byte_bad  (byte_bad),
    .byte_data (byte_data),
    .evt_valid (evt_valid),
    .evt       (evt),
    .frame_err (frame_err)
  );

  assign evt_code  = evt.code;
  assign evt_break = evt.brk;
  assign evt_ext   = evt.ext;
endmodule

// File: tb/kbd_event_rx_bench.sv
module kbd_event_rx_bench;
  localparam int FILT = 4;
  localparam int IDLE = 400;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ps2c = 1'b1;
  logic ps2d = 1'b1;
  logic       evt_valid;
  logic [7:0] evt_code;
  logic       evt_break;
  logic       evt_ext;
  logic       frame_err;

  always #4 clk = ~clk;

  kbd_event_rx #(.FILTER_LEN(FILT), .IDLE_LIMIT(IDLE)) u_kbd_event_rx (
    .clk(clk), .rst(rst), .ps2_clk_in(ps2c), .ps2_data_in(ps2d),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_break(evt_break),
    .evt_ext(evt_ext), .frame_err(frame_err));

  int tests = 0;
  int fails = 0;
  int ev_cnt = 0;
  int err_cnt = 0;
  bit double_pulse = 0;
  bit prev_v = 0;
  bit prev_e = 0;
  logic [7:0] last_code = 0;
  logic last_brk = 0;
  logic last_ext = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (evt_valid) begin
        ev_cnt++;
        last_code = evt_code;
        last_brk  = evt_break;
        last_ext  = evt_ext;
      end
      if (frame_err) err_cnt++;
      if ((evt_valid && prev_v) || (frame_err && prev_e)) double_pulse = 1;
      prev_v = evt_valid;
      prev_e = frame_err;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [10:0] bits, input int count);
    for (int i = 0; i < count; i++) begin
      ps2d = bits[i];
      wcyc(HALF);
      ps2c = 1'b0;
      wcyc(HALF);
      ps2c = 1'b1;
    end
    ps2d = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic par;
    par = ~(^b) ^ bad_par;
    send_bits({~bad_stop, par, b, 1'b0}, 11);
    wcyc(30);
  endtask

  task automatic expect_event(input string tag, input int ev0, input logic [7:0] code,
                              input logic brk, input logic ext);
    chk(ev_cnt == ev0 + 1, {tag, " event count"}, ev_cnt, ev0 + 1);
    chk(last_code == code, {tag, " code"}, last_code, code);
    chk(last_brk == brk, {tag, " break"}, last_brk, brk);
    chk(last_ext == ext, {tag, " ext"}, last_ext, ext);
  endtask

  task automatic t_reset;
    chk(evt_valid == 0 && frame_err == 0, "R1 strobes", {evt_valid, frame_err}, 0);
    chk(evt_code == 0 && evt_break == 0 && evt_ext == 0, "R1 event regs",
        {evt_break, evt_ext, evt_code}, 0);
  endtask

  task automatic t_make;
    int e0;
    e0 = ev_cnt; send_frame(8'h1C, 0, 0); expect_event("R2 make 1C", e0, 8'h1C, 0, 0);
    e0 = ev_cnt; send_frame(8'h5A, 0, 0); expect_event("R2 make 5A", e0, 8'h5A, 0, 0);
  endtask

  task automatic t_break;
    int e0;
    e0 = ev_cnt;
    send_frame(8'hF0, 0, 0);
    chk(ev_cnt == e0, "R3 prefix silent", ev_cnt, e0);
    send_frame(8'h1C, 0, 0);
    expect_event("R3 release", e0, 8'h1C, 1, 0);
  endtask

  task automatic t_ext;
    int e0;
    e0 = ev_cnt;
    send_frame(8'hE0, 0, 0); send_frame(8'h75, 0, 0);
    expect_event("R4 ext make", e0, 8'h75, 0, 1);
    e0 = ev_cnt;
    send_frame(8'hE0, 0, 0); send_frame(8'hF0, 0, 0);
    chk(ev_cnt == e0, "R4 prefixes silent", ev_cnt, e0);
    send_frame(8'h75, 0, 0);
    expect_event("R4 ext release", e0, 8'h75, 1, 1);
  endtask

  task automatic t_repeat;
    int e0;
    e0 = ev_cnt;
    for (int k = 0; k < 3; k++) send_frame(8'h23, 0, 0);
    chk(ev_cnt == e0 + 3, "R5 repeat count", ev_cnt, e0 + 3);
    chk(last_code == 8'h23 && last_brk == 0, "R5 repeat make", {last_brk, last_code}, 8'h23);
  endtask

  task automatic t_parity;
    int e0, r0;
    e0 = ev_cnt; r0 = err_cnt;
    send_frame(8'hF0, 0, 0);
    send_frame(8'h1C, 1, 0);
    chk(ev_cnt == e0, "R6 no event on parity error", ev_cnt, e0);
    chk(err_cnt == r0 + 1, "R6 error pulse", err_cnt, r0 + 1);
    send_frame(8'h1C, 0, 0);
    expect_event("R6 prefix cleared", e0, 8'h1C, 0, 0);
  endtask

  task automatic t_stop;
    int e0, r0;
    e0 = ev_cnt; r0 = err_cnt;
    send_frame(8'hE0, 0, 0);
    send_frame(8'h2B, 0, 1);
    chk(ev_cnt == e0, "R7 no event on stop error", ev_cnt, e0);
    chk(err_cnt == r0 + 1, "R7 error pulse", err_cnt, r0 + 1);
    send_frame(8'h2B, 0, 0);
    expect_event("R7 prefix cleared", e0, 8'h2B, 0, 0);
  endtask

  task automatic t_timeout;
    int e0, r0;
    e0 = ev_cnt; r0 = err_cnt;
    send_bits({2'b11, 8'h55, 1'b0}, 4);
    wcyc(IDLE + 100);
    send_frame(8'h44, 0, 0);
    expect_event("R8 after abandoned frame", e0, 8'h44, 0, 0);
    chk(err_cnt == r0, "R8 no error", err_cnt, r0);
  endtask

  task automatic t_glitch;
    int e0, r0;
    e0 = ev_cnt; r0 = err_cnt;
    ps2d = 1'b0;
    wcyc(10);
    ps2c = 1'b0;
    wcyc(FILT - 2);
    ps2c = 1'b1;
    wcyc(10);
    ps2d = 1'b1;
    wcyc(10);
    send_frame(8'h3A, 0, 0);
    expect_event("R9 glitch ignored", e0, 8'h3A, 0, 0);
    chk(err_cnt == r0, "R9 no error", err_cnt, r0);
  endtask

  task automatic t_idle_fall;
    int e0, r0;
    e0 = ev_cnt; r0 = err_cnt;
    ps2c = 1'b0;
    wcyc(HALF);
    ps2c = 1'b1;
    wcyc(HALF);
    send_frame(8'h16, 0, 0);
    expect_event("R11 idle edge not a start", e0, 8'h16, 0, 0);
    chk(err_cnt == r0, "R11 no error", err_cnt, r0);
  endtask

  task automatic t_strobe;
    chk(!double_pulse, "R10 strobes one cycle", double_pulse, 0);
    wcyc(50);
    chk(evt_valid == 0, "R10 strobe low", evt_valid, 0);
    chk(evt_code == last_code && evt_break == last_brk && evt_ext == last_ext,
        "R10 event held", {evt_break, evt_ext, evt_code}, {last_brk, last_ext, last_code});
  endtask

  initial begin
    wcyc(5);
    rst = 1'b0;
    wcyc(2);
    t_reset;
    t_make;
    t_break;
    t_ext;
    t_repeat;
    t_parity;
    t_stop;
    t_timeout;
    t_glitch;
    t_idle_fall;
    t_strobe;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule